// File: doc/BRIEF.md
# Descriptor Table Entry Locator

This block turns a 16-bit segment selector into the linear address of its 8-byte descriptor. The descriptor may live in the global table or in the local table. It also reports whether that descriptor may be reached. The block keeps two table registers. The global one holds a base and a limit. The local one holds the selector it was loaded from, a base, a limit and an attribute byte. Both registers are written through a single load port. A write to the local register is checked against the global table first, and it is cached only when the selector points to a valid global entry.

A lookup is presented for one cycle. Its result appears on the next cycle as a done pulse, the descriptor address and a fault flag. The lookup kind input tells the block whether the selector is only being placed in a data-segment register or is being used for a memory access. The two kinds differ only for the null selector: placing it is harmless, but using it faults. Descriptor fetch, privilege checks and paging are handled elsewhere.

Top module: `seg_desc_locator`

## Requirements
- R1: After reset the block is in the following state. The outputs out_done, out_fault, ld_ack and ld_fault are 0. ldt_sel_q and ldt_attr_q are 0. The global base and limit are 0. The local register holds the null state.
- R2: A lookup with lk_valid high gives out_done high for exactly the next cycle. In that cycle out_addr equals the table base plus (lk_sel[15:3] × 8), taken modulo 2^32. Selector bits 1:0 have no effect on the result.
- R3: Selector bit 2 picks the table. A value of 0 selects the global register and a value of 1 selects the local register.
- R4: Limits are inclusive. A non-null lookup faults if and only if index×8+7 is greater than the selected table's limit, so a limit of 0 admits a single byte.
- R5: A null selector has bits 15:2 all zero. A null selector with lk_access=0, meaning it is only placed in a register, never faults, whatever the global limit.
- R6: A null selector with lk_access=1, meaning it is used for a memory access, always faults.
- R7: A lookup with bit 2 set faults while the local register holds the null state.
- R8: A load with ld_local=0 replaces the global base and limit. It gives ld_ack high on the next cycle with ld_fault low.
- R9: A load with ld_local=1 is accepted when its selector has bit 2 clear and a non-zero index, and index×8+7 is within the global limit. It then caches the selector, base, limit and attribute byte. ld_fault stays low.
- R10: A load with ld_local=1 is rejected when its selector has bit 2 set, or when its index lies beyond the global limit. It gives ld_fault=1 and leaves the local register unchanged.
- R11: A load with ld_local=1 and a null selector is accepted without fault. The local register is put in the null state, with the selector stored, the attribute, base and limit cleared.
- R12: When a load and a lookup come in the same cycle, the lookup uses the table registers as they were before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Table register write strobe |
| ld_local | input | 1 | 0 writes the global register, 1 writes the local register |
| ld_base | input | 32 | Base linear address to store |
| ld_limit | input | 16 | Inclusive limit to store |
| ld_sel | input | 16 | Selector of the local table's global entry (local writes only) |
| ld_attr | input | 8 | Attribute byte to cache (local writes only) |
| ld_ack | output | 1 | Load completed, one cycle after ld_valid |
| ld_fault | output | 1 | Load rejected, valid with ld_ack |
| lk_valid | input | 1 | Lookup request strobe |
| lk_sel | input | 16 | Selector to look up |
| lk_access | input | 1 | 1 for a memory access, 0 for a register placement |
| out_done | output | 1 | Lookup result valid |
| out_addr | output | 32 | Linear address of the descriptor |
| out_fault | output | 1 | General-protection fault for the lookup |
| ldt_sel_q | output | 16 | Selector cached in the local register |
| ldt_attr_q | output | 8 | Attribute byte cached in the local register |

## Verification
A wrong base or limit inside a table register is not visible when it is written. It shows only on the next lookup that selects that table, as a wrong out_addr or as a fault at an index next to the limit. The bench therefore sets limits exactly at index×8+6 and index×8+7 and looks up immediately afterwards. A local register that wrongly accepts or drops a load shows on ldt_sel_q in the cycle after the load. A wrong null flag shows on the first lookup with bit 2 set that follows.

// File: rtl/seg_desc_locator.sv
module seg_desc_locator #(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 16,
  parameter int SEL_W  = 16,
  parameter int ATTR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic              ld_local,
  input  logic [ADDR_W-1:0] ld_base,
  input  logic [LIM_W-1:0]  ld_limit,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [ATTR_W-1:0] ld_attr,
  output logic              ld_ack,
  output logic              ld_fault,
  input  logic              lk_valid,
  input  logic [SEL_W-1:0]  lk_sel,
  input  logic              lk_access,
  output logic              out_done,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_fault,
  output logic [SEL_W-1:0]  ldt_sel_q,
  output logic [ATTR_W-1:0] ldt_attr_q
);
  localparam int IDX_W = SEL_W - 3;
  localparam int CMP_W = (SEL_W > LIM_W) ? SEL_W : LIM_W;

  logic [ADDR_W-1:0] gdt_base, ldt_base;
  logic [LIM_W-1:0]  gdt_limit, ldt_limit;
  logic              ldt_null;

  // lookup path
  wire [IDX_W-1:0]  lk_idx     = lk_sel[SEL_W-1:3];
  wire              lk_ti      = lk_sel[2];
  wire              lk_is_null = !lk_ti && (lk_idx == '0);
  wire [LIM_W-1:0]  lk_lim     = lk_ti ? ldt_limit : gdt_limit;
  wire [ADDR_W-1:0] lk_base    = lk_ti ? ldt_base : gdt_base;
  wire [CMP_W-1:0]  lk_last    = CMP_W'({lk_idx, 3'b111});
  wire              lk_over    = lk_last > CMP_W'(lk_lim);
  wire              lk_flt     = lk_is_null ? lk_access : ((lk_ti && ldt_null) || lk_over);
  wire [ADDR_W-1:0] lk_addr    = lk_base + ADDR_W'({lk_idx, 3'b000});

  // load path
  wire [IDX_W-1:0]  ld_idx     = ld_sel[SEL_W-1:3];
  wire              ld_is_null = !ld_sel[2] && (ld_idx == '0);
  wire [CMP_W-1:0]  ld_last    = CMP_W'({ld_idx, 3'b111});
  wire              ld_over    = ld_last > CMP_W'(gdt_limit);
  wire              ld_rej     = ld_local && (ld_sel[2] || (!ld_is_null && ld_over));
  wire              ldt_wr     = ld_valid && ld_local && !ld_rej;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gdt_base   <= '0;
      gdt_limit  <= '0;
      ldt_base   <= '0;
      ldt_limit  <= '0;
      ldt_null   <= 1'b1;
      ldt_sel_q  <= '0;
      ldt_attr_q <= '0;
      ld_ack     <= 1'b0;
      ld_fault   <= 1'b0;
      out_done   <= 1'b0;
      out_fault  <= 1'b0;
      out_addr   <= '0;
    end else begin
      ld_ack   <= ld_valid;
      ld_fault <= ld_valid && ld_rej;
      if (ld_valid && !ld_local) begin
        gdt_base  <= ld_base;
        gdt_limit <= ld_limit;
      end
      if (ldt_wr) begin
        ldt_sel_q <= ld_sel;
        ldt_null  <= ld_is_null;
        if (ld_is_null) begin
          ldt_base   <= '0;
          ldt_limit  <= '0;
          ldt_attr_q <= '0;
        end else begin
          ldt_base   <= ld_base;
          ldt_limit  <= ld_limit;
          ldt_attr_q <= ld_attr;
        end
      end
      out_done  <= lk_valid;
      out_fault <= lk_valid && lk_flt;
      if (lk_valid) out_addr <= lk_addr;
    end
  end
endmodule

module seg_desc_locator_chk #(
  parameter int SEL_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_valid,
  input logic             ld_local,
  input logic [SEL_W-1:0] ld_sel,
  input logic             ld_ack,
  input logic             ld_fault,
  input logic             lk_valid,
  input logic [SEL_W-1:0] lk_sel,
  input logic             lk_access,
  input logic             out_done,
  input logic             out_fault,
  input logic [SEL_W-1:0] ldt_sel_q,
  input logic             ldt_null
);
  // R2
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> out_done);
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !out_done);
  // R5
  null_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_sel[SEL_W-1:2] == '0 && !lk_access) |=> !out_fault);
  // R6
  null_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_sel[SEL_W-1:2] == '0 && lk_access) |=> out_fault);
  // R7
  ldt_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_sel[2] && ldt_null) |=> out_fault);
  // R8
  load_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> ld_ack);
  // R8
  gdt_load_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_local) |=> !ld_fault);
  // R10
  ldt_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_local && ld_sel[2]) |=> (ld_fault && $stable(ldt_sel_q)));
endmodule

bind seg_desc_locator seg_desc_locator_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_local(ld_local),
  .ld_sel(ld_sel), .ld_ack(ld_ack), .ld_fault(ld_fault),
  .lk_valid(lk_valid), .lk_sel(lk_sel), .lk_access(lk_access),
  .out_done(out_done), .out_fault(out_fault),
  .ldt_sel_q(ldt_sel_q), .ldt_null(ldt_null)
);

// File: tb/sim_seg_desc_locator.sv
`timescale 1ns/100ps
module sim_seg_desc_locator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0, ld_local = 1'b0;
  logic [31:0] ld_base = '0;
  logic [15:0] ld_limit = '0, ld_sel = '0;
  logic [7:0]  ld_attr = '0;
  logic        ld_ack, ld_fault;
  logic        lk_valid = 1'b0, lk_access = 1'b0;
  logic [15:0] lk_sel = '0;
  logic        out_done, out_fault;
  logic [31:0] out_addr;
  logic [15:0] ldt_sel_q;
  logic [7:0]  ldt_attr_q;

  always #2.5 clk = ~clk;

  seg_desc_locator u0 (.*);

  int compared = 0, mismatched = 0;

  // reference model state
  logic [31:0] m_gbase = '0, m_lbase = '0;
  logic [15:0] m_glim = '0, m_llim = '0, m_lsel = '0;
  logic [7:0]  m_lattr = '0;
  logic        m_lnull = 1'b1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] exp_lk(input logic [15:0] s, input logic acc);
    logic [12:0] idx = s[15:3];
    logic [31:0] a;
    logic f;
    if (!s[2]) begin
      a = m_gbase + {16'd0, idx, 3'b000};
      if (idx == 0) f = acc;
      else f = ({idx, 3'b111} > m_glim);
    end else begin
      a = m_lbase + {16'd0, idx, 3'b000};
      f = m_lnull || ({idx, 3'b111} > m_llim);
    end
    return {f, a};
  endfunction

  function automatic logic exp_ldrej(input logic loc, input logic [15:0] s);
    if (!loc) return 1'b0;
    if (s[2]) return 1'b1;
    if (s[15:3] == 0) return 1'b0;
    return {s[15:3], 3'b111} > m_glim;
  endfunction

  task automatic step(input logic ldv, input logic ldl, input logic [31:0] b, input logic [15:0] lim,
                      input logic [15:0] s, input logic [7:0] a,
                      input logic lkv, input logic [15:0] ks, input logic kacc, input string tag);
    logic [32:0] e;
    logic rej;
    @(negedge clk);
    ld_valid = ldv; ld_local = ldl; ld_base = b; ld_limit = lim; ld_sel = s; ld_attr = a;
    lk_valid = lkv; lk_sel = ks; lk_access = kacc;
    e = exp_lk(ks, kacc);
    rej = exp_ldrej(ldl, s);
    @(posedge clk); #1;
    chk(ld_ack == ldv, "R8", 64'(ld_ack), 64'(ldv));
    if (ldv) chk(ld_fault == rej, tag, 64'(ld_fault), 64'(rej));
    chk(out_done == lkv, "R2", 64'(out_done), 64'(lkv));
    if (lkv) begin
      chk(out_fault == e[32], tag, 64'(out_fault), 64'(e[32]));
      chk(out_addr == e[31:0], tag, 64'(out_addr), 64'(e[31:0]));
    end
    if (ldv && !ldl) begin m_gbase = b; m_glim = lim; end
    if (ldv && ldl && !rej) begin
      m_lsel = s;
      if (!s[2] && s[15:3] == 0) begin
        m_lnull = 1'b1; m_lbase = '0; m_llim = '0; m_lattr = '0;
      end else begin
        m_lnull = 1'b0; m_lbase = b; m_llim = lim; m_lattr = a;
      end
    end
    if (ldv && ldl) begin
      chk(ldt_sel_q == m_lsel, tag, 64'(ldt_sel_q), 64'(m_lsel));
      chk(ldt_attr_q == m_lattr, tag, 64'(ldt_attr_q), 64'(m_lattr));
    end
    @(negedge clk);
    ld_valid = 1'b0; lk_valid = 1'b0;
  endtask

  task automatic lookup(input logic [15:0] ks, input logic kacc, input string tag);
    step(1'b0, 1'b0, '0, '0, '0, '0, 1'b1, ks, kacc, tag);
  endtask

  task automatic gload(input logic [31:0] b, input logic [15:0] lim);
    step(1'b1, 1'b0, b, lim, '0, '0, 1'b0, '0, 1'b0, "R8");
  endtask

  task automatic lload(input logic [31:0] b, input logic [15:0] lim, input logic [15:0] s,
                       input logic [7:0] a, input string tag);
    step(1'b1, 1'b1, b, lim, s, a, 1'b0, '0, 1'b0, tag);
  endtask

  initial begin
    #(5.0 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5E1EC7);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(!out_done && !out_fault && !ld_ack && !ld_fault, "R1", 64'({out_done, out_fault, ld_ack, ld_fault}), 64'd0);
    chk(ldt_sel_q == 0 && ldt_attr_q == 0, "R1", 64'({ldt_sel_q, ldt_attr_q}), 64'd0);
    lookup(16'h0008, 1'b0, "R1");   // global limit 0 after reset
    lookup(16'h000C, 1'b0, "R7");   // local null after reset

    gload(32'h0000_1000, 16'h003F);
    lookup({13'd7, 3'b011}, 1'b1, "R2");  // RPL bits ignored
    lookup({13'd7, 3'b000}, 1'b0, "R2");
    lookup({13'd8, 3'b000}, 1'b1, "R4");
    gload(32'h0000_1000, 16'h003E);
    lookup({13'd7, 3'b000}, 1'b1, "R4");
    lookup({13'd6, 3'b000}, 1'b1, "R4");

    gload(32'h0000_2000, 16'h0000);
    lookup(16'h0003, 1'b0, "R5");
    lookup(16'h0000, 1'b1, "R6");
    lookup(16'h0002, 1'b1, "R6");

    gload(32'h0000_3000, 16'h00FF);
    lload(32'h0004_0000, 16'h0017, {13'd5, 3'b100}, 8'h82, "R10");
    lload(32'h0004_0000, 16'h0017, {13'd5, 3'b000}, 8'h82, "R9");
    lookup({13'd2, 3'b100}, 1'b1, "R3");
    lookup({13'd3, 3'b100}, 1'b1, "R4");
    lookup({13'd2, 3'b000}, 1'b1, "R3");
    lload(32'h0005_0000, 16'h00FF, {13'd32, 3'b000}, 8'h99, "R10");
    lookup({13'd2, 3'b100}, 1'b0, "R10");
    lload(32'h0005_0000, 16'h00FF, 16'h0001, 8'h99, "R11");
    lookup({13'd0, 3'b100}, 1'b0, "R11");

    gload(32'hFFFF_FFF8, 16'hFFFF);
    lookup({13'd2, 3'b000}, 1'b0, "R2");

    // R12: load and lookup in the same cycle
    step(1'b1, 1'b0, 32'h0000_8000, 16'h0007, '0, '0, 1'b1, {13'd4, 3'b000}, 1'b0, "R12");
    lookup({13'd4, 3'b000}, 1'b0, "R12");

    for (int i = 0; i < 400; i++) begin
      int pick = $urandom_range(0, 9);
      logic [15:0] s = {3'd0, 10'($urandom_range(0, 15)), 3'($urandom_range(0, 7))};
      if (pick == 0)
        gload($urandom, 16'($urandom_range(0, 159)));
      else if (pick == 1)
        lload($urandom, 16'($urandom_range(0, 159)), s, 8'($urandom), "R9");
      else if (pick == 2)
        step(1'b1, 1'($urandom_range(0, 1)), $urandom, 16'($urandom_range(0, 159)), s, 8'($urandom),
             1'b1, {3'd0, 10'($urandom_range(0, 15)), 3'($urandom_range(0, 7))}, 1'($urandom_range(0, 1)), "R12");
      else
        lookup(s, 1'($urandom_range(0, 1)), "R4");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule